// File: doc/BRIEF.md
# Rotating Priority Channel Output Formatter

This block sits between eight serial-word receivers and a host processor. Each receiver raises a pending flag when it holds a complete 32-bit word and a 3-bit error code. The formatter picks one pending channel by round-robin priority and raises a ready flag. It then presents the selected word on a 16-bit host bus as a fixed sequence of output items. The host takes the items one at a time by strobing an active-low output-select line while it holds an active-low chip enable low.

Two output shapes are supported, chosen when a channel is granted. Word mode gives three 16-bit items. Byte mode gives five 8-bit items on the low half of the bus. The host may stop after any item. Raising chip enable always ends the read: the ready flag drops, the channel gets a one-cycle release pulse, and a short holdoff passes before the next grant. A channel whose message was cut short reports that fact with its next message.

Top module: `rrobin_msg_port`

## Requirements
- R1: Arbitration is round-robin. After channel k is released, the search for the next grant starts at channel k+1 (wrapping after 7), and the first pending channel in that order is granted.
- R2: While reset is held, and right after it, the ready flag is low, the bus is zero and no release pulse is driven. The first grant after reset searches from channel 0.
- R3: Word mode, item 0 is the header: bits 15:13 hold the error code, bits 12:10 hold the channel number in binary, bits 9:8 hold received word bits 9:8 (SDI), and bits 7:0 hold received word bits 7:0 (label).
- R4: Word mode, item 1 is received word bits 23:8, and item 2 is received word bits 31:24 in bus bits 15:8 with bus bits 7:0 zero.
- R5: Byte mode (byte_mode_i high at grant), bus bits 15:8 are zero. The five bytes are, in order: header low byte, header high byte, item-1 low byte, item-1 high byte, and received word bits 31:24.
- R6: Ready rises once the holdoff has expired, chip enable is high and some channel is pending. It then stays high, with a stable message, until the read ends.
- R7: A rising edge of chip enable while ready is high makes ready low on the next cycle. On that same cycle, release_o pulses for exactly one cycle with only the granted channel's bit set.
- R8: Output-select strobes given while chip enable is high do not advance the item sequence.
- R9: If a channel was released before all of its items were read, its next message carries error code 001, unless the receiver's own code for that word is nonzero, in which case the receiver's code is shown. A fully read message clears the condition.
- R10: After a release, ready stays low for HOLDOFF+1 cycles, counted from the cycle in which release_o is high.
- R11: The bus presents item n while n strobes have completed; each strobe advances on the rising edge of the output-select line. Once all items are read (3 in word mode, 5 in byte mode), further strobes give a zero bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_valid_i | input | 8 | Per-channel pending flag, held until released |
| ch_word_i | input | 256 | Received 32-bit word of each channel, channel c at bits 32c+31:32c |
| ch_err_i | input | 24 | Receiver error code of each channel, channel c at bits 3c+2:3c |
| byte_mode_i | input | 1 | 1 selects five-byte output, 0 selects three-word output |
| ce_n_i | input | 1 | Active-low chip enable |
| os_n_i | input | 1 | Active-low output-select strobe |
| rdy_o | output | 1 | A message is available |
| bus_o | output | 16 | Current output item |
| release_o | output | 8 | One-cycle release pulse to the serviced channel |

## Verification
The assertions assume synchronous host inputs, and that each receiver keeps its pending flag, word and error code steady until it sees its release pulse. The bench channel model follows this rule: it changes a channel's inputs only while that channel is not pending, and it drops the flag on the cycle it sees the release. The host model only asserts chip enable while ready is high, and raises it only after some number of completed strobes. That number is drawn from zero to one past the item count, so both early termination and reads past the end take place within the assumed protocol.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
    localparam int WORD_W = 32;
    localparam int ERR_W  = 3;
    localparam int BUS_W  = 16;
    localparam int IDX_W  = 3;

    typedef enum logic {ST_IDLE, ST_SHOW} st_e;

    // Builds output item k for a captured message.
    function automatic logic [BUS_W-1:0] fmt_item(
        input logic [WORD_W-1:0] w,
        input logic [ERR_W-1:0]  e,
        input logic [2:0]        id,
        input logic              bm,
        input logic [IDX_W-1:0]  k
    );
        logic [BUS_W-1:0] hdr, mid, top;
        logic [BUS_W-1:0] r;
        hdr = {e, id, w[9:8], w[7:0]};
        mid = w[23:8];
        top = {w[31:24], 8'h00};
        r   = '0;
        if (bm) begin
            case (k)
                3'd0: r = {8'h00, hdr[7:0]};
                3'd1: r = {8'h00, hdr[15:8]};
                3'd2: r = {8'h00, mid[7:0]};
                3'd3: r = {8'h00, mid[15:8]};
                3'd4: r = {8'h00, top[15:8]};
                default: r = '0;
            endcase
        end else begin
            case (k)
                3'd0: r = hdr;
                3'd1: r = mid;
                3'd2: r = top;
                default: r = '0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/rmp_arbiter.sv
module rmp_arbiter #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req_i,
    input  logic [CW-1:0]  ptr_i,
    output logic [CW-1:0]  grant_o,
    output logic           any_o
);
    always_comb begin
        grant_o = '0;
        any_o   = |req_i;
        // Walk from the farthest offset down so the nearest request wins.
        for (int k = NCH - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr_i) + k) % NCH;
            if (req_i[idx]) grant_o = CW'(idx);
        end
    end
endmodule

// File: rtl/rmp_item_mux.sv
module rmp_item_mux
    import rmp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [ERR_W-1:0]  err_i,
    input  logic [2:0]        id_i,
    input  logic              bm_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BUS_W-1:0]  item_o
);
    always_comb item_o = fmt_item(word_i, err_i, id_i, bm_i, idx_i);
endmodule

// File: rtl/rmp_overrun_flags.sv
module rmp_overrun_flags #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire_i,
    input  logic [CW-1:0]  ch_i,
    input  logic           full_i,
    output logic [NCH-1:0] flag_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        logic ovr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ovr_q <= 1'b0;
            else if (fire_i && ch_i == CW'(g))  ovr_q <= !full_i;
        end
        assign flag_o[g] = ovr_q;
    end
endmodule

// File: rtl/rrobin_msg_port.sv
module rrobin_msg_port
    import rmp_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int HOLDOFF = 4,
    localparam int CW     = $clog2(NCH),
    localparam int HW     = $clog2(HOLDOFF + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ch_valid_i,
    input  logic [NCH*WORD_W-1:0] ch_word_i,
    input  logic [NCH*ERR_W-1:0]  ch_err_i,
    input  logic                  byte_mode_i,
    input  logic                  ce_n_i,
    input  logic                  os_n_i,
    output logic                  rdy_o,
    output logic [BUS_W-1:0]      bus_o,
    output logic [NCH-1:0]        release_o
);
    localparam logic [IDX_W-1:0] N_WORDS = 3'd3;
    localparam logic [IDX_W-1:0] N_BYTES = 3'd5;

    typedef struct packed {
        st_e              st;
        logic [CW-1:0]    ch;
        logic [CW-1:0]    ptr;
        logic [WORD_W-1:0] word;
        logic [ERR_W-1:0] err;
        logic             bm;
        logic [IDX_W-1:0] reads;
        logic [HW-1:0]    hold;
        logic             ce_n;
        logic             os_n;
        logic [NCH-1:0]   rel;
    } regs_t;

    regs_t q, d;

    logic [CW-1:0]    grant;
    logic             any_req;
    logic [NCH-1:0]   ovr;
    logic [ERR_W-1:0] rx_err, code;
    logic [IDX_W-1:0] n_items;
    logic             fire, strobe;
    logic [BUS_W-1:0] item;

    rmp_arbiter #(.NCH(NCH)) u_arb (
        .req_i   (ch_valid_i),
        .ptr_i   (q.ptr),
        .grant_o (grant),
        .any_o   (any_req)
    );

    rmp_overrun_flags #(.NCH(NCH)) u_ovr (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .ch_i   (q.ch),
        .full_i (q.reads == n_items),
        .flag_o (ovr)
    );

    rmp_item_mux u_mux (
        .word_i (q.word),
        .err_i  (q.err),
        .id_i   (3'(q.ch)),
        .bm_i   (q.bm),
        .idx_i  (q.reads),
        .item_o (item)
    );

    always_comb begin
        n_items = q.bm ? N_BYTES : N_WORDS;
        rx_err  = ch_err_i[grant*ERR_W +: ERR_W];
        code    = (rx_err != '0) ? rx_err : (ovr[grant] ? 3'b001 : 3'b000);
        fire    = (q.st == ST_SHOW) && ce_n_i && !q.ce_n;
        strobe  = (q.st == ST_SHOW) && !ce_n_i && !q.ce_n && os_n_i && !q.os_n;

        d      = q;
        d.ce_n = ce_n_i;
        d.os_n = os_n_i;
        d.rel  = '0;
        if (q.hold != '0) d.hold = q.hold - 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (q.hold == '0 && ce_n_i && any_req) begin
                    d.st    = ST_SHOW;
                    d.ch    = grant;
                    d.word  = ch_word_i[grant*WORD_W +: WORD_W];
                    d.err   = code;
                    d.bm    = byte_mode_i;
                    d.reads = '0;
                end
            end
            default: begin
                if (fire) begin
                    d.st        = ST_IDLE;
                    d.rel[q.ch] = 1'b1;
                    d.hold      = HW'(HOLDOFF);
                    d.ptr       = (q.ch == CW'(NCH - 1)) ? '0 : q.ch + 1'b1;
                end else if (strobe && q.reads < n_items) begin
                    d.reads = q.reads + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ce_n <= 1'b1;
            q.os_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdy_o     = (q.st == ST_SHOW);
    assign bus_o     = rdy_o ? item : '0;
    assign release_o = q.rel;

    // Granted channel must be one that is pending.
    assert_grant_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> ch_valid_i[q.ch]);

    // Chip enable rising during a read ends it with a single release bit.
    assert_ce_rise_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && ce_n_i && !q.ce_n) |=> (!rdy_o && $onehot(release_o)));

    assert_release_onehot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(release_o));

    // Message content does not change while ready stays high.
    assert_msg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !(ce_n_i && !q.ce_n)) |=> (rdy_o && $stable(q.word) && $stable(q.ch)));

    // Strobes with chip enable high leave the item index alone.
    assert_os_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && ce_n_i && q.ce_n) |=> $stable(q.reads));

    assert_reads_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.reads <= n_items);

    assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold != '0) |=> !rdy_o);
endmodule

// File: tb/rrobin_msg_port_bench.sv
`timescale 1ns/100ps
module rrobin_msg_port_bench;
    localparam int NCH = 8;
    localparam int HOLDOFF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ch_valid;
    logic [NCH*32-1:0] ch_word;
    logic [NCH*3-1:0] ch_err;
    logic byte_mode = 1'b0;
    logic ce_n = 1'b1;
    logic os_n = 1'b1;
    logic rdy;
    logic [15:0] bus;
    logic [NCH-1:0] rel;

    logic [31:0] words [NCH];
    logic [2:0]  errs  [NCH];
    logic [NCH-1:0] pend = '0;
    logic [NCH-1:0] ovr_m = '0;
    int ptr_m = 0;
    bit chk_hold = 0;
    bit auto_refill = 0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_word[c*32 +: 32] = words[c];
            ch_err[c*3 +: 3]    = errs[c];
        end
        ch_valid = pend;
    end

    rrobin_msg_port #(.NCH(NCH), .HOLDOFF(HOLDOFF)) u_rrobin_msg_port (
        .clk(clk), .rst_n(rst_n), .ch_valid_i(ch_valid), .ch_word_i(ch_word),
        .ch_err_i(ch_err), .byte_mode_i(byte_mode), .ce_n_i(ce_n), .os_n_i(os_n),
        .rdy_o(rdy), .bus_o(bus), .release_o(rel)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
            summary();
        end
    end

    function automatic logic [15:0] exp_item(logic [31:0] w, logic [2:0] e, int c, bit bm, int k);
        logic [15:0] h, m, t;
        h = {e, 3'(c), w[9:0]};
        m = w[23:8];
        t = {w[31:24], 8'h00};
        if (bm) begin
            case (k)
                0: return {8'h00, h[7:0]};
                1: return {8'h00, h[15:8]};
                2: return {8'h00, m[7:0]};
                3: return {8'h00, m[15:8]};
                4: return {8'h00, t[15:8]};
                default: return 16'h0000;
            endcase
        end
        case (k)
            0: return h;
            1: return m;
            2: return t;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic pend_ch(input int c, input logic [2:0] e);
        words[c] = $urandom;
        errs[c]  = e;
        pend[c]  = 1'b1;
    endtask

    task automatic refill();
        for (int c = 0; c < NCH; c++)
            if (!pend[c] && ($urandom % 2 == 0))
                pend_ch(c, ($urandom % 4 == 0) ? 3'(1 + $urandom % 7) : 3'd0);
        if (pend == '0) pend_ch($urandom % NCH, 3'd0);
        byte_mode = 1'($urandom % 2);
    endtask

    task automatic do_msg(input int nreads, input bit pre_os);
        int cyc, ch, n;
        logic [2:0] ecode;
        string tag;
        bit from_ovr;
        cyc = 0;
        while (!rdy && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(rdy === 1'b1, "R6 ready after pending", 32'(rdy), 1);
        if (chk_hold) check(cyc == HOLDOFF, "R10 holdoff length", 32'(cyc), HOLDOFF);
        ch = -1;
        for (int k = NCH - 1; k >= 0; k--)
            if (pend[(ptr_m + k) % NCH]) ch = (ptr_m + k) % NCH;
        from_ovr = (errs[ch] == 3'd0) && ovr_m[ch];
        ecode = (errs[ch] != 3'd0) ? errs[ch] : (ovr_m[ch] ? 3'b001 : 3'b000);
        n = byte_mode ? 5 : 3;
        if (pre_os) begin
            for (int p = 0; p < 2; p++) begin
                os_n = 1'b0; @(negedge clk);
                os_n = 1'b1; @(negedge clk);
            end
        end
        ce_n = 1'b0;
        @(negedge clk);
        for (int r = 0; r < nreads; r++) begin
            os_n = 1'b0;
            @(negedge clk);
            if (r >= n)          tag = "R11 past end";
            else if (pre_os && r == 0) tag = "R8 strobe with ce high";
            else if (from_ovr && r < 2) tag = "R9 overrun code";
            else if (byte_mode)  tag = "R5 byte item";
            else if (r == 0)     tag = "R3 header";
            else                 tag = "R4 data item";
            check(bus === exp_item(words[ch], ecode, ch, byte_mode, r), tag,
                  32'(bus), 32'(exp_item(words[ch], ecode, ch, byte_mode, r)));
            if (r == 0 && !byte_mode)
                check(bus[12:10] === 3'(ch), "R1 granted channel", 32'(bus[12:10]), 32'(ch));
            os_n = 1'b1;
            @(negedge clk);
        end
        ce_n = 1'b1;
        @(negedge clk);
        check(rdy === 1'b0, "R7 ready drops", 32'(rdy), 0);
        check(rel === NCH'(1 << ch), "R7 release pulse", 32'(rel), 32'(1 << ch));
        pend[ch]  = 1'b0;
        ovr_m[ch] = (nreads < n);
        ptr_m     = (ch + 1) % NCH;
        if (auto_refill) refill();
        @(negedge clk);
        check(rel === '0, "R7 release one cycle", 32'(rel), 0);
        check(rdy === 1'b0, "R10 ready low in holdoff", 32'(rdy), 0);
        chk_hold = 1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < NCH; c++) begin
            words[c] = '0;
            errs[c]  = '0;
        end
        for (int c = 0; c < NCH; c++) pend_ch(c, 3'd0);
        repeat (3) @(negedge clk);
        check(rdy === 1'b0, "R2 reset ready", 32'(rdy), 0);
        check(bus === 16'h0, "R2 reset bus", 32'(bus), 0);
        check(rel === '0, "R2 reset release", 32'(rel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R1: all pending, order must be 0..7 from reset
        for (int i = 0; i < NCH; i++) do_msg(3, 0);
        check(pend === '0, "R1 all eight served in turn", 32'(pend), 0);
        // R9: partial read on channel 5, then a report of 001, then cleared
        byte_mode = 1'b1; pend_ch(5, 3'd0);
        do_msg(1, 0);
        pend_ch(5, 3'd0);
        do_msg(5, 0);
        byte_mode = 1'b0; pend_ch(5, 3'd0);
        do_msg(3, 0);
        // R9: receiver's own code wins over overrun
        pend_ch(2, 3'd0);
        do_msg(0, 0);
        pend_ch(2, 3'b010);
        do_msg(4, 0);
        // R8: strobes while chip enable high
        pend_ch(6, 3'd0);
        do_msg(3, 1);
        // R11 in byte mode: six strobes
        byte_mode = 1'b1; pend_ch(1, 3'd0);
        do_msg(6, 0);
        // random phase
        auto_refill = 1;
        refill();
        for (int m = 0; m < 300; m++)
            do_msg($urandom % ((byte_mode ? 5 : 3) + 2), ($urandom % 4) == 0);
        summary();
    end
endmodule